// File: doc/BRIEF.md
# Banked Memory Decoder with Write Protection

This block sits between an 8-bit CPU's 16-bit address bus and its memories. Each access is steered to one of three targets: system RAM at the bottom of the map, a ROM of up to 1MB seen through two windows, or a small window of internal I/O registers. The block holds no memory of its own. It produces chip enables, the upper ROM address lines and a qualified RAM write enable. The CPU still drives the low address bits to the memories directly.

Two ROM windows are provided. The upper half of the address space always shows the last 32KB of the ROM, which is pages 62 and 63. The quarter at 0x4000–0x7FFF shows whichever 16KB page a six-bit page register selects. The page number goes out unchanged as ROM address bits 19..14. A smaller ROM therefore ignores the upper page bits, because it has no pins for them.

A write lock guards the top of RAM. Software sets a size code n. When the lock is armed, every write that falls in the uppermost 2^n bytes of RAM is dropped. Reads are never affected, and writes below the region still go through. Software uses this to keep configuration and audit data from being overwritten by stray writes.

Top module: `mem_bank_decoder`

## Requirements
- R1: With an access strobe active, addresses 0x0000–0x1FFF assert only `ram_cs`. Addresses 0x2000–0x3FBF assert no enable.
- R2: Addresses 0x3FC0–0x3FFF assert only `io_cs`. Reads from an unused offset in that window return 0. Writes to an unused offset change no register.
- R3: Addresses 0x4000–0x7FFF assert only `rom_cs`, and `rom_page` equals the page register.
- R4: Addresses 0x8000–0xFFFF assert only `rom_cs`, and `rom_page` is 62 + address bit 14, whatever the page register holds.
- R5: The page register is at 0x3FFC. A write loads data bits 5..0 and ignores bits 7..6. The new value takes effect from the next cycle. A read returns the value in bits 5..0 with zeros above. It resets to 0.
- R6: The lock enable is bit 0 of 0x3FFD and the lock size code is bits 3..0 of 0x3FFE. Both read back with zeros in the other bits, and both reset to 0, which is unlocked.
- R7: With the lock disabled, `ram_we` equals `cpu_wr` for every RAM address.
- R8: With the lock enabled and size code n, a RAM write at offset a is suppressed exactly when a >= 8192 - 2^min(n,13). Any code of 13 or more protects all of RAM.
- R9: A RAM read asserts `ram_cs` whatever the lock state, and never asserts `ram_we`.
- R10: With neither `cpu_rd` nor `cpu_wr` active, no chip enable is asserted, and at most one enable is ever active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| ram_cs | output | 1 | System RAM chip enable |
| ram_we | output | 1 | RAM write enable after the lock |
| rom_cs | output | 1 | ROM chip enable |
| rom_page | output | 6 | ROM address bits 19..14 |
| io_cs | output | 1 | Internal I/O window select |
| io_rdata | output | 8 | Register read data, zero when no register read is in progress |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high in the same cycle. They also assume that the address and strobes hold steady across a clock edge, because register writes commit at the edge. The bench drives at most one strobe at a time. It moves the address only between edges, and it raises `cpu_wr` on the register window only inside its single-cycle write task. The RAM-range write sweeps run with no edge able to alter state, because writes into RAM do not touch any register.

// File: rtl/mbd_pkg.sv
`timescale 1ns/1ps
// Package: shared region type for the banked memory decoder.
// Assumes a 16-bit CPU address space split into RAM, I/O window and ROM windows.
package mbd_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned DATA_W = 8;

    // Which target an address belongs to
    typedef enum logic [2:0] {
        RGN_NONE  = 3'd0,
        RGN_RAM   = 3'd1,
        RGN_IO    = 3'd2,
        RGN_BANK  = 3'd3,
        RGN_FIXED = 3'd4
    } region_e;

endpackage

// File: rtl/mbd_addr_decode.sv
`timescale 1ns/1ps
// Module: mbd_addr_decode
// Classifies a CPU address into one target region. Purely combinational.
// Assumes the RAM size and the I/O window both lie below 0x4000, with the
// I/O window above the end of RAM.
module mbd_addr_decode
    import mbd_pkg::*;
#(
    parameter int unsigned RAM_AW  = 13,
    parameter int unsigned IO_AW   = 6,
    parameter logic [15:0] IO_BASE = 16'h3FC0
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn
);

    localparam int unsigned HI_W = ADDR_W - IO_AW;

    logic in_io;
    logic in_ram;

    // Window membership tests
    assign in_io  = (addr[ADDR_W-1:IO_AW] == IO_BASE[ADDR_W-1:IO_AW]);
    assign in_ram = (addr[ADDR_W-1:RAM_AW] == '0);

    // Priority order: fixed ROM, banked ROM, I/O window, RAM
    always_comb begin
        if (addr[ADDR_W-1])
            rgn = RGN_FIXED;
        else if (addr[ADDR_W-2])
            rgn = RGN_BANK;
        else if (in_io)
            rgn = RGN_IO;
        else if (in_ram)
            rgn = RGN_RAM;
        else
            rgn = RGN_NONE;
    end

    wire unused_hi = ^HI_W;

endmodule

// File: rtl/mbd_io_regs.sv
`timescale 1ns/1ps
// Module: mbd_io_regs
// Holds the ROM page register, the lock enable and the lock size code, and
// returns them on register reads. Unused offsets read 0 and ignore writes.
// Assumes wr_en and rd_en are already qualified with the I/O window select.
module mbd_io_regs
    import mbd_pkg::*;
#(
    parameter int unsigned IO_AW       = 6,
    parameter int unsigned PAGE_W      = 6,
    parameter int unsigned SIZE_W      = 4,
    parameter logic [5:0]  PAGE_OFS    = 6'h3C,
    parameter logic [5:0]  LOCK_EN_OFS = 6'h3D,
    parameter logic [5:0]  LOCK_SZ_OFS = 6'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IO_AW-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] page_q,
    output logic              lock_en_q,
    output logic [SIZE_W-1:0] lock_sz_q,
    output logic [DATA_W-1:0] rdata
);

    // Register writes, synchronous active-low reset to the unlocked page-0 state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q    <= '0;
            lock_en_q <= 1'b0;
            lock_sz_q <= '0;
        end else if (wr_en) begin
            case (ofs)
                PAGE_OFS[IO_AW-1:0]:    page_q    <= wdata[PAGE_W-1:0];
                LOCK_EN_OFS[IO_AW-1:0]: lock_en_q <= wdata[0];
                LOCK_SZ_OFS[IO_AW-1:0]: lock_sz_q <= wdata[SIZE_W-1:0];
                default: ;
            endcase
        end
    end

    // Read multiplexer, zero outside a register read
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (ofs)
                PAGE_OFS[IO_AW-1:0]:    rdata = DATA_W'(page_q);
                LOCK_EN_OFS[IO_AW-1:0]: rdata = DATA_W'(lock_en_q);
                LOCK_SZ_OFS[IO_AW-1:0]: rdata = DATA_W'(lock_sz_q);
                default:                rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mbd_ram_guard.sv
`timescale 1ns/1ps
// Module: mbd_ram_guard
// Gates RAM writes against a lock covering the top 2^code bytes of RAM.
// A code at or above RAM_AW covers the whole RAM. Assumes wr_req is already
// qualified with the RAM region.
module mbd_ram_guard #(
    parameter int unsigned RAM_AW = 13,
    parameter int unsigned SIZE_W = 4
) (
    input  logic              wr_req,
    input  logic [RAM_AW-1:0] offset,
    input  logic              lock_en,
    input  logic [SIZE_W-1:0] lock_sz,
    output logic              hit,
    output logic              ram_we
);

    logic [RAM_AW-1:0] mask;

    // Bit g of the mask is set when it lies above the protected span
    for (genvar g = 0; g < RAM_AW; g++) begin : g_mask
        assign mask[g] = (32'(lock_sz) <= 32'(g));
    end

    // Region hit: every mask bit of the offset is one
    assign hit    = ((offset & mask) == mask);
    // Write passes unless the lock is armed and the offset is inside the region
    assign ram_we = wr_req && !(lock_en && hit);

endmodule

// File: rtl/mem_bank_decoder.sv
`timescale 1ns/1ps
// Module: mem_bank_decoder
// Top level: decodes CPU accesses into RAM, banked/fixed ROM and I/O window
// enables, drives the ROM page lines and applies the top-of-RAM write lock.
// Assumes cpu_rd and cpu_wr are never active together, and that the address
// is stable across the clock edge of a register write.
module mem_bank_decoder
    import mbd_pkg::*;
#(
    parameter int unsigned RAM_AW      = 13,
    parameter int unsigned PAGE_W      = 6,
    parameter int unsigned SIZE_W      = 4,
    parameter int unsigned IO_AW       = 6,
    parameter logic [15:0] IO_BASE     = 16'h3FC0,
    parameter logic [5:0]  PAGE_OFS    = 6'h3C,
    parameter logic [5:0]  LOCK_EN_OFS = 6'h3D,
    parameter logic [5:0]  LOCK_SZ_OFS = 6'h3E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    output logic        ram_cs,
    output logic        ram_we,
    output logic        rom_cs,
    output logic [5:0]  rom_page,
    output logic        io_cs,
    output logic [7:0]  io_rdata
);

    localparam int unsigned FIX_ONES = PAGE_W - 1;

    region_e           rgn;
    logic              access;
    logic              in_io;
    logic [PAGE_W-1:0] page_q;
    logic              lock_en_q;
    logic [SIZE_W-1:0] lock_sz_q;
    logic              lock_hit;

    mbd_addr_decode #(
        .RAM_AW (RAM_AW),
        .IO_AW  (IO_AW),
        .IO_BASE(IO_BASE)
    ) u_dec (
        .addr(cpu_addr),
        .rgn (rgn)
    );

    // Any strobe means a bus cycle is in progress
    assign access = cpu_rd || cpu_wr;
    assign in_io  = (rgn == RGN_IO);

    mbd_io_regs #(
        .IO_AW      (IO_AW),
        .PAGE_W     (PAGE_W),
        .SIZE_W     (SIZE_W),
        .PAGE_OFS   (PAGE_OFS),
        .LOCK_EN_OFS(LOCK_EN_OFS),
        .LOCK_SZ_OFS(LOCK_SZ_OFS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr && in_io),
        .rd_en    (cpu_rd && in_io),
        .ofs      (cpu_addr[IO_AW-1:0]),
        .wdata    (cpu_wdata),
        .page_q   (page_q),
        .lock_en_q(lock_en_q),
        .lock_sz_q(lock_sz_q),
        .rdata    (io_rdata)
    );

    mbd_ram_guard #(
        .RAM_AW(RAM_AW),
        .SIZE_W(SIZE_W)
    ) u_guard (
        .wr_req (cpu_wr && (rgn == RGN_RAM)),
        .offset (cpu_addr[RAM_AW-1:0]),
        .lock_en(lock_en_q),
        .lock_sz(lock_sz_q),
        .hit    (lock_hit),
        .ram_we (ram_we)
    );

    // Chip enables, qualified by an active strobe
    always_comb begin
        ram_cs = access && (rgn == RGN_RAM);
        rom_cs = access && ((rgn == RGN_BANK) || (rgn == RGN_FIXED));
        io_cs  = access && in_io;
    end

    // Upper ROM lines: fixed window forces the top two pages, else the page register
    always_comb begin
        if (rgn == RGN_FIXED)
            rom_page = {{FIX_ONES{1'b1}}, cpu_addr[ADDR_W-2]};
        else
            rom_page = page_q;
    end

    wire unused_hit = lock_hit;

endmodule

// File: rtl/mbd_checker.sv
`timescale 1ns/1ps
// Module: mbd_checker
// Concurrent checks on the decoder, bound into every instance of the top.
// Assumes a single strobe per cycle.
module mbd_checker #(
    parameter int unsigned RAM_AW   = 13,
    parameter int unsigned PAGE_W   = 6,
    parameter logic [5:0]  PAGE_OFS = 6'h3C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              ram_cs,
    input logic              ram_we,
    input logic              rom_cs,
    input logic              io_cs,
    input logic [PAGE_W-1:0] rom_page,
    input logic [PAGE_W-1:0] page_q,
    input logic              lock_en_q
);

    assert_one_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs, rom_cs, io_cs}) && ((cpu_rd || cpu_wr) || !(ram_cs || rom_cs || io_cs)));

    assert_fixed_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_rd || cpu_wr) && cpu_addr[15]) |->
            (rom_cs && (&rom_page[PAGE_W-1:1]) && (rom_page[0] == cpu_addr[14])));

    assert_bank_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs && cpu_addr[15:14] == 2'b01) |-> (rom_page == page_q));

    assert_page_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && io_cs && cpu_addr[5:0] == PAGE_OFS) |=> (page_q == $past(cpu_wdata[PAGE_W-1:0])));

    assert_we_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && cpu_wr));

    assert_unlocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && ram_cs && !lock_en_q) |-> ram_we);

    assert_top_byte_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_en_q && cpu_wr && ram_cs && (&cpu_addr[RAM_AW-1:0])) |-> !ram_we);

    assert_read_no_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |-> !ram_we);

endmodule

bind mem_bank_decoder mbd_checker #(
    .RAM_AW  (RAM_AW),
    .PAGE_W  (PAGE_W),
    .PAGE_OFS(PAGE_OFS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .cpu_rd   (cpu_rd),
    .cpu_wr   (cpu_wr),
    .ram_cs   (ram_cs),
    .ram_we   (ram_we),
    .rom_cs   (rom_cs),
    .io_cs    (io_cs),
    .rom_page (rom_page),
    .page_q   (page_q),
    .lock_en_q(lock_en_q)
);

// File: tb/sim_mem_bank_decoder.sv
`timescale 1ns/1ps
// Bench: sweeps the address map, every page value and every lock size code,
// computing expected enables and write gating arithmetically.
module sim_mem_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        ram_cs, ram_we, rom_cs, io_cs;
    logic [5:0]  rom_page;
    logic [7:0]  io_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mem_bank_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .ram_cs(ram_cs), .ram_we(ram_we),
        .rom_cs(rom_cs), .rom_page(rom_page), .io_cs(io_cs), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            finish_run();
        end
    end

    // One register write cycle, committing at the next rising edge
    task automatic io_wr(input logic [5:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = 16'h3FC0 | 16'(ofs);
        cpu_wdata = d;
        cpu_rd = 1'b0;
        cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic io_rd(input logic [5:0] ofs, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = 16'h3FC0 | 16'(ofs);
        cpu_rd = 1'b1;
        #1 d = io_rdata;
        cpu_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] rv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R5, R6
        io_rd(6'h3C, rv); check("R5 page reset", rv, 0);
        io_rd(6'h3D, rv); check("R6 lock enable reset", rv, 0);
        io_rd(6'h3E, rv); check("R6 lock size reset", rv, 0);
        @(negedge clk);
        cpu_addr = 16'h1FFF; cpu_wr = 1'b1;
        #1 check("R7 unlocked top byte after reset", ram_we, 1);
        cpu_wr = 1'b0;

        // No strobe: R10
        foreach (cpu_addr[i]) begin
            cpu_addr = 16'(1) << i;
            #1 check("R10 idle enables", {ram_cs, rom_cs, io_cs}, 0);
        end

        // Full address sweep with reads: R1 R2 R3 R4
        io_wr(6'h3C, 8'h2A);
        @(negedge clk);
        for (int a = 0; a < 65536; a++) begin
            logic ex_ram, ex_io, ex_rom;
            cpu_addr = 16'(a);
            cpu_rd = 1'b1;
            ex_ram = (a < 8192);
            ex_io  = (a >= 16'h3FC0) && (a < 16'h4000);
            ex_rom = (a >= 16'h4000);
            #1;
            if (a < 16'h4000) begin
                check("R1 R2 low map enables", {ram_cs, io_cs, rom_cs}, {ex_ram, ex_io, ex_rom});
                if (ex_io && a != 16'h3FFC && a != 16'h3FFD && a != 16'h3FFE)
                    check("R2 unused offset reads zero", io_rdata, 0);
            end else if (a < 16'h8000) begin
                check("R3 banked enables", {ram_cs, io_cs, rom_cs}, 3'b001);
                check("R3 banked page", rom_page, 8'h2A);
            end else begin
                check("R4 fixed enables", {ram_cs, io_cs, rom_cs}, 3'b001);
                check("R4 fixed page", rom_page, 62 + ((a >> 14) & 1));
            end
            #1;
        end
        cpu_rd = 1'b0;

        // Page sweep: R5 R3 R4
        for (int p = 0; p < 64; p++) begin
            io_wr(6'h3C, 8'(p) | 8'hC0);
            io_rd(6'h3C, rv);
            check("R5 page readback", rv, p);
            @(negedge clk);
            cpu_rd = 1'b1;
            cpu_addr = 16'h4000; #1 check("R3 page at window start", rom_page, p);
            cpu_addr = 16'h7FFF; #1 check("R3 page at window end", rom_page, p);
            cpu_addr = 16'h8000; #1 check("R4 page 62 independent of register", rom_page, 62);
            cpu_addr = 16'hFFFF; #1 check("R4 page 63 independent of register", rom_page, 63);
            cpu_rd = 1'b0;
        end

        // Lock enable and size fields: R6
        io_wr(6'h3D, 8'hFF);
        io_rd(6'h3D, rv); check("R6 lock enable readback", rv, 1);
        io_wr(6'h3E, 8'hF7);
        io_rd(6'h3E, rv); check("R6 lock size readback", rv, 7);

        // Lock sweep over every size code: R8 R9
        for (int c = 0; c < 16; c++) begin
            int sz;
            io_wr(6'h3E, 8'(c));
            sz = (c >= 13) ? 8192 : (1 << c);
            @(negedge clk);
            for (int a = 0; a < 8192; a++) begin
                cpu_addr = 16'(a);
                cpu_wr = 1'b1;
                #0.5 check("R8 locked write gating", ram_we, (a >= 8192 - sz) ? 0 : 1);
                #0.5;
            end
            cpu_wr = 1'b0;
            @(negedge clk);
            cpu_rd = 1'b1;
            cpu_addr = 16'h1FFF;
            #1 check("R9 read in locked region", {ram_cs, ram_we}, 2'b10);
            cpu_addr = 16'(8192 - sz);
            #1 check("R9 read at region base", {ram_cs, ram_we}, 2'b10);
            cpu_rd = 1'b0;
        end

        // Disarm the lock: R7
        io_wr(6'h3D, 8'h00);
        @(negedge clk);
        for (int a = 0; a < 8192; a += 31) begin
            cpu_addr = 16'(a);
            cpu_wr = 1'b1;
            #1 check("R7 unlocked write", ram_we, 1);
        end
        cpu_addr = 16'h1FFF;
        #1 check("R7 unlocked top byte", ram_we, 1);
        cpu_wr = 1'b0;

        // Writes to unused offsets change nothing: R2
        io_wr(6'h3C, 8'h15);
        io_wr(6'h00, 8'hFF);
        io_wr(6'h3F, 8'hFF);
        io_wr(6'h3B, 8'hFF);
        io_rd(6'h3C, rv); check("R2 page untouched by unused writes", rv, 8'h15);
        io_rd(6'h3D, rv); check("R2 lock enable untouched", rv, 0);
        io_rd(6'h3E, rv); check("R2 lock size untouched", rv, 15);
        io_rd(6'h3F, rv); check("R2 unused offset still zero", rv, 0);

        finish_run();
    end

endmodule